// File: doc/BRIEF.md
# Two-Comparator Window Monitor

This block sits behind a pair of comparators that watch the same analog signal. One compares it against an upper threshold, the other against a lower threshold. From their two state bits it classifies the signal as above, inside or below the window and presents that as a 2-bit region code. When the signal moves into a region named by a 2-bit trigger select, it sets a sticky window flag and can emit a one-cycle event pulse. Software clears the flag by writing one to it. A separate enable, set and cleared by strobes, decides whether the flag drives the interrupt line.

A small state machine controls the block. It has three states. OFF holds while window mode is disabled. PRIME waits after enabling until both comparators report ready. RUN tracks and flags transitions. The named transitions are:
- OFF to PRIME, when the enable rises.
- PRIME to RUN, on the first cycle both comparators are ready. The region is loaded silently on that cycle.
- PRIME or RUN back to OFF, when the enable drops. The region reads as above (0) from that edge on.

Top module: `wmon_top`

## Requirements
- R1: The region code is 0 (above) when the upper comparator is high. It is 2 (below) when the upper comparator is low and the lower comparator is low. It is 1 (inside) when the upper comparator is low and the lower comparator is high. Code 3 never appears. The upper comparator takes priority.
- R2: While in PRIME or RUN, the region changes only on a cycle where both ready inputs are high. Otherwise it holds.
- R3: Enabling takes the machine from OFF to PRIME. At the first both-ready cycle it loads the region from the inputs, sets no flag and emits no event.
- R4: While the enable is low, the region reads 0, no flag is set and no event is emitted. The outputs change at the clock edge that samples the enable low.
- R5: The trigger select uses 0 for above, 1 for inside and 2 for below. With one of these selected, the flag sets when the region changes into the selected region. It does not set again while the region stays there.
- R6: Trigger select 3 (outside) sets the flag on any change into the above or below region. This includes a direct move from above to below.
- R7: The flag is sticky. A one on the clear strobe clears it. A set in the same cycle wins over the clear.
- R8: The interrupt output equals the flag AND the interrupt enable. The enable-set strobe sets the enable and the enable-clear strobe clears it. Clear wins if both strobes arrive together.
- R9: The event output pulses high for the cycle after a flag-setting transition, but only if the event enable is high. The flag itself does not depend on the event enable.
- R10: After reset, the region is 0 and the flag, interrupt enable, interrupt and event are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| upper_cmp | input | 1 | Upper-threshold comparator state (high: signal above upper) |
| lower_cmp | input | 1 | Lower-threshold comparator state (high: signal above lower) |
| upper_rdy | input | 1 | Upper comparator result valid |
| lower_rdy | input | 1 | Lower comparator result valid |
| win_en | input | 1 | Window mode enable |
| trig_sel | input | 2 | Trigger region: 0 above, 1 inside, 2 below, 3 outside |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en_set | input | 1 | Interrupt-enable set strobe |
| irq_en_clr | input | 1 | Interrupt-enable clear strobe |
| evt_en | input | 1 | Event output enable |
| win_region | output | 2 | Current region code |
| win_flag | output | 1 | Sticky window flag |
| win_irq | output | 1 | Interrupt request |
| win_evt | output | 1 | One-cycle event pulse |

## Verification
The main function is tried with a sequence of comparator pairs that walks the signal through every region under each trigger select. The sequence includes moves into the selected region, stays inside it, and moves into regions that are not selected. These cases separate a flag raised on entry from one raised on level. The outside select gets a direct above-to-below jump, which catches a design that needs an intermediate inside step. The illegal pair (upper high, lower low) checks the priority of the upper comparator. Directed cases cover:
- withheld ready bits;
- a clear strobe that coincides with a set;
- the gating of the interrupt and event outputs;
- the silent load on re-enable.

// File: rtl/wmon_pkg.sv
package wmon_pkg;

    localparam int REGION_W = 2;
    localparam int SEL_W    = 2;

    typedef enum logic [REGION_W-1:0] {
        RGN_ABOVE  = 2'd0,
        RGN_INSIDE = 2'd1,
        RGN_BELOW  = 2'd2
    } region_e;

    typedef enum logic [SEL_W-1:0] {
        TRIG_ABOVE   = 2'd0,
        TRIG_INSIDE  = 2'd1,
        TRIG_BELOW   = 2'd2,
        TRIG_OUTSIDE = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PRIME = 2'd1,
        ST_RUN   = 2'd2
    } mon_state_e;

    // True when region r satisfies trigger t
    function automatic logic trig_match(input trig_e t, input region_e r);
        logic m;
        unique case (t)
            TRIG_ABOVE:   m = (r == RGN_ABOVE);
            TRIG_INSIDE:  m = (r == RGN_INSIDE);
            TRIG_BELOW:   m = (r == RGN_BELOW);
            TRIG_OUTSIDE: m = (r == RGN_ABOVE) || (r == RGN_BELOW);
            default:      m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/wmon_classify.sv
module wmon_classify
    import wmon_pkg::*;
(
    input  logic    upper_cmp,
    input  logic    lower_cmp,
    output region_e region
);

    // Upper comparator has priority; the third code is never produced
    always_comb begin
        if (upper_cmp)
            region = RGN_ABOVE;
        else if (!lower_cmp)
            region = RGN_BELOW;
        else
            region = RGN_INSIDE;
    end

endmodule

// File: rtl/wmon_fsm.sv
module wmon_fsm
    import wmon_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    win_en,
    input  logic    both_rdy,
    input  region_e new_region,
    input  trig_e   trig,
    output region_e region_q,
    output logic    hit
);

    mon_state_e st_q, st_d;

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:   if (win_en) st_d = ST_PRIME;
            ST_PRIME: if (!win_en) st_d = ST_OFF;
                      else if (both_rdy) st_d = ST_RUN;
            ST_RUN:   if (!win_en) st_d = ST_OFF;
            default:  st_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_OFF;
        else
            st_q <= st_d;
    end

    // Output process: transition detect
    always_comb begin
        hit = 1'b0;
        unique case (st_q)
            ST_OFF:   hit = 1'b0;
            ST_PRIME: hit = 1'b0;
            ST_RUN:   hit = win_en && both_rdy && (new_region != region_q)
                            && trig_match(trig, new_region);
            default:  hit = 1'b0;
        endcase
    end

    // Region register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            region_q <= RGN_ABOVE;
        else if (!win_en)
            region_q <= RGN_ABOVE;
        else if (both_rdy && st_q != ST_OFF)
            region_q <= new_region;
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        region_q != 2'd3); // R1
    AST_HOLD_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_OFF && win_en && !both_rdy) |=> $stable(region_q)); // R2
    AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRIME) |-> !hit); // R3
    AST_STAY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (both_rdy && new_region == region_q) |-> !hit); // R5

endmodule

// File: rtl/wmon_flags.sv
module wmon_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    input  logic irq_en_set,
    input  logic irq_en_clr,
    input  logic evt_en,
    output logic flag_q,
    output logic irq,
    output logic evt_q
);

    logic ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            ien_q  <= 1'b0;
            evt_q  <= 1'b0;
        end else begin
            if (hit)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
            if (irq_en_clr)
                ien_q <= 1'b0;
            else if (irq_en_set)
                ien_q <= 1'b1;
            evt_q <= hit && evt_en;
        end
    end

    assign irq = flag_q && ien_q;

    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !flag_q); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q); // R7
    AST_EVT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(evt_en)); // R9
    AST_IEN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en_clr |=> !irq); // R8

endmodule

// File: rtl/wmon_top.sv
module wmon_top
    import wmon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upper_cmp,
    input  logic                lower_cmp,
    input  logic                upper_rdy,
    input  logic                lower_rdy,
    input  logic                win_en,
    input  logic [SEL_W-1:0]    trig_sel,
    input  logic                flag_clr,
    input  logic                irq_en_set,
    input  logic                irq_en_clr,
    input  logic                evt_en,
    output logic [REGION_W-1:0] win_region,
    output logic                win_flag,
    output logic                win_irq,
    output logic                win_evt
);

    region_e new_region;
    region_e region_q;
    logic    hit;
    logic    both_rdy;

    assign both_rdy = upper_rdy && lower_rdy;

    wmon_classify u_cls (
        .upper_cmp (upper_cmp),
        .lower_cmp (lower_cmp),
        .region    (new_region)
    );

    wmon_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_en     (win_en),
        .both_rdy   (both_rdy),
        .new_region (new_region),
        .trig       (trig_e'(trig_sel)),
        .region_q   (region_q),
        .hit        (hit)
    );

    wmon_flags u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .flag_clr   (flag_clr),
        .irq_en_set (irq_en_set),
        .irq_en_clr (irq_en_clr),
        .evt_en     (evt_en),
        .flag_q     (win_flag),
        .irq        (win_irq),
        .evt_q      (win_evt)
    );

    assign win_region = region_q;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !win_en |=> (!win_evt && win_region == 2'd0)); // R4
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        win_irq |-> win_flag); // R8

endmodule

// File: tb/sim_wmon_top.sv
module sim_wmon_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       upper_cmp = 1'b0, lower_cmp = 1'b1;
    logic       upper_rdy = 1'b1, lower_rdy = 1'b1;
    logic       win_en = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       flag_clr = 1'b0, irq_en_set = 1'b0, irq_en_clr = 1'b0;
    logic       evt_en = 1'b0;
    logic [1:0] win_region;
    logic       win_flag, win_irq, win_evt;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wmon_top u0 (
        .clk(clk), .rst_n(rst_n),
        .upper_cmp(upper_cmp), .lower_cmp(lower_cmp),
        .upper_rdy(upper_rdy), .lower_rdy(lower_rdy),
        .win_en(win_en), .trig_sel(trig_sel),
        .flag_clr(flag_clr), .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr),
        .evt_en(evt_en),
        .win_region(win_region), .win_flag(win_flag),
        .win_irq(win_irq), .win_evt(win_evt)
    );

    // Vector: [6:5] trig, [4] upper, [3] lower, [2:1] expected region, [0] expected flag/event
    localparam logic [6:0] VEC [14] = '{
        {2'd0, 1'b1, 1'b1, 2'd0, 1'b1},  // R5 inside->above, sel above
        {2'd0, 1'b1, 1'b1, 2'd0, 1'b0},  // R5 stay above
        {2'd1, 1'b0, 1'b1, 2'd1, 1'b1},  // R5 into inside
        {2'd1, 1'b0, 1'b1, 2'd1, 1'b0},  // R5 stay inside
        {2'd2, 1'b0, 1'b0, 2'd2, 1'b1},  // R5 into below
        {2'd2, 1'b0, 1'b0, 2'd2, 1'b0},  // R5 stay below
        {2'd0, 1'b0, 1'b1, 2'd1, 1'b0},  // R5 into inside, sel above
        {2'd3, 1'b1, 1'b1, 2'd0, 1'b1},  // R6 into above
        {2'd3, 1'b0, 1'b0, 2'd2, 1'b1},  // R6 above->below direct
        {2'd3, 1'b0, 1'b1, 2'd1, 1'b0},  // R6 inside not outside
        {2'd3, 1'b0, 1'b0, 2'd2, 1'b1},  // R6 into below
        {2'd1, 1'b1, 1'b0, 2'd0, 1'b0},  // R1 upper priority
        {2'd2, 1'b0, 1'b1, 2'd1, 1'b0},  // R1 inside code
        {2'd0, 1'b1, 1'b1, 2'd0, 1'b1}   // R5 into above
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at negedge, let one posedge pass, sample just after it
    task automatic tick();
        @(posedge clk);
        #1;
        @(negedge clk);
        flag_clr   = 1'b0;
        irq_en_set = 1'b0;
        irq_en_clr = 1'b0;
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R10 region", int'(win_region), 0);
        chk("R10 flag", int'(win_flag), 0);
        chk("R10 irq", int'(win_irq), 0);
        chk("R10 evt", int'(win_evt), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Enable with signal inside: OFF->PRIME, then silent load
        win_en = 1'b1; evt_en = 1'b1; irq_en_set = 1'b1;
        upper_cmp = 1'b0; lower_cmp = 1'b1;
        tick();
        chk("R3 prime region", int'(win_region), 0);
        tick();
        chk("R3 load region", int'(win_region), 1);
        chk("R3 load no flag", int'(win_flag), 0);

        foreach (VEC[i]) begin
            trig_sel  = VEC[i][6:5];
            upper_cmp = VEC[i][4];
            lower_cmp = VEC[i][3];
            flag_clr  = 1'b1;
            tick();
            chk($sformatf("R5/R6 vec%0d region", i), int'(win_region), int'(VEC[i][2:1]));
            chk($sformatf("R5/R6 vec%0d flag", i), int'(win_flag), int'(VEC[i][0]));
            chk($sformatf("R9 vec%0d evt", i), int'(win_evt), int'(VEC[i][0]));
            chk($sformatf("R8 vec%0d irq", i), int'(win_irq), int'(VEC[i][0]));
        end

        // R7 flag sticky, then cleared; region is above here
        tick();
        chk("R7 sticky", int'(win_flag), 1);
        flag_clr = 1'b1;
        tick();
        chk("R7 cleared", int'(win_flag), 0);

        // R2 hold while one ready low
        trig_sel = 2'd2; upper_cmp = 1'b0; lower_cmp = 1'b0; lower_rdy = 1'b0;
        tick();
        chk("R2 hold region", int'(win_region), 0);
        chk("R2 hold flag", int'(win_flag), 0);
        lower_rdy = 1'b1;
        tick();
        chk("R2 update region", int'(win_region), 2);
        chk("R2 update flag", int'(win_flag), 1);

        // R9 event disabled, flag still sets
        flag_clr = 1'b1; evt_en = 1'b0;
        trig_sel = 2'd1; upper_cmp = 1'b0; lower_cmp = 1'b1;
        tick();
        chk("R9 flag without evt", int'(win_flag), 1);
        chk("R9 evt gated", int'(win_evt), 0);

        // R8 enable strobes, clear wins over set
        irq_en_clr = 1'b1; irq_en_set = 1'b1;
        tick();
        chk("R8 irq masked", int'(win_irq), 0);
        chk("R8 flag kept", int'(win_flag), 1);
        irq_en_set = 1'b1;
        tick();
        chk("R8 irq unmasked", int'(win_irq), 1);

        // R4 disabled: region 0, no flag, no event
        flag_clr = 1'b1; evt_en = 1'b1; win_en = 1'b0;
        tick();
        chk("R4 region off", int'(win_region), 0);
        chk("R4 flag off", int'(win_flag), 0);
        trig_sel = 2'd2; upper_cmp = 1'b0; lower_cmp = 1'b0;
        tick();
        chk("R4 no flag", int'(win_flag), 0);
        chk("R4 no evt", int'(win_evt), 0);

        // R3 re-enable while below: silent load, then running
        win_en = 1'b1;
        tick();
        tick();
        chk("R3 reload region", int'(win_region), 2);
        chk("R3 reload no flag", int'(win_flag), 0);
        chk("R3 reload no evt", int'(win_evt), 0);
        upper_cmp = 1'b0; lower_cmp = 1'b1;
        tick();
        upper_cmp = 1'b0; lower_cmp = 1'b0;
        tick();
        chk("R3 running flag", int'(win_flag), 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule